// File: doc/BRIEF.md
# CAN interrupt aggregator

This block collects the event and status conditions of a CAN controller and turns them into four maskable interrupt request lines: transmit, receive, wakeup and error. Eleven sources feed these lines. Three are the empty states of the transmit buffers. Three are events: a received frame, bus activity while asleep, and a receive overrun. The last five are error-confinement levels, which the block derives by comparing the receive and transmit error counters with fixed limits. Frame handling, bit timing and counter arithmetic sit outside the block. The counters arrive as plain inputs.

Each source has a status bit in a flag register and a matching bit in an enable register. A CPU reads either register through `reg_sel_i`. Writing a 1 to a latched flag bit clears it. The transmit-empty bits are not latched: they track the buffer status.

Each error counter feeds its own classifier state machine with four states: ACTIVE (counter below 96), WARNING (96 to 127), PASSIVE (above 127) and BUSOFF (above 255, transmit counter only). The state follows the counter every cycle, so any state can move to any other in one cycle. There are two kinds of transition:
- An upward transition (ACTIVE to WARNING, ACTIVE or WARNING to PASSIVE, any lower state to BUSOFF) raises one set pulse for each limit it crosses.
- A downward transition (recovery) raises nothing, but it re-arms the crossed limits.

Top module: `can_irq_aggregator`

## Requirements
- R1: While reset is asserted, the flag register reads 0x007 (all transmit-empty bits set, all other flags clear), the enable register reads 0x000, and all four interrupt outputs are 0.
- R2: Flag bits [2:0] show `buf_empty_i[2:0]` one clock after it is sampled. Writes to these bits have no effect.
- R3: `irq_tx_o` is the OR of the enabled transmit-empty flag bits, registered one clock after the flags.
- R4: Flag bit 3 (receive) sets on a rising edge of `rx_done_i`. A level held high sets it only once: after a clear it stays 0 until the input falls and rises again. `irq_rx_o` follows the enabled bit one clock later.
- R5: Flag bit 4 (wakeup) sets on a rising edge of `sleep_i & bus_act_i`. Bus activity outside sleep leaves it clear. `irq_wake_o` follows the enabled bit one clock later.
- R6: A write with `reg_sel_i`=0 clears every latched flag bit (bits 3 to 10) whose data bit is 1, and leaves the bits written with 0 unchanged. If a set condition for a bit occurs in the same clock as its clear, the bit stays set.
- R7: Flag bit 6 (receive warning) and bit 7 (transmit warning) set when their counter moves from below 96 to 96 or more.
- R8: Flag bit 8 (receive passive) and bit 9 (transmit passive) set when their counter moves from 127 or below to above 127.
- R9: Flag bit 10 (bus-off) sets when the transmit counter moves from 255 or below to above 255. No value of the receive counter sets it.
- R10: Flag bit 5 (overrun) sets on a rising edge of `overrun_i`. `irq_err_o` is the registered OR of the enabled bits 5 to 10.
- R11: The enable register (`reg_sel_i`=1) has the same bit layout as the flag register and is loaded whole by a write. A masked flag still latches and reads back. Enabling it later raises its interrupt one clock after the enable write.
- R12: A counter jump that crosses several limits in one clock sets every crossed flag at once. After the counter falls back below a limit, crossing it again sets the flag again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| buf_empty_i | input | 3 | Empty status of transmit buffers 0 to 2 |
| rx_done_i | input | 1 | Frame accepted into the receive buffer |
| sleep_i | input | 1 | Controller is in internal sleep mode |
| bus_act_i | input | 1 | Activity seen on the CAN bus |
| overrun_i | input | 1 | Receive overrun event |
| rx_err_cnt_i | input | 9 | Receive error counter |
| tx_err_cnt_i | input | 9 | Transmit error counter |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects the flag register, 1 the enable register |
| reg_wdata_i | input | 11 | Register write data |
| reg_rdata_o | output | 11 | Contents of the selected register |
| irq_tx_o | output | 1 | Transmit interrupt request |
| irq_rx_o | output | 1 | Receive interrupt request |
| irq_wake_o | output | 1 | Wakeup interrupt request |
| irq_err_o | output | 1 | Error interrupt request |

## Verification
The hardest situations to reach are the ones where timing between two inputs matters:
- A rising edge of a source in the same clock as the write that clears its flag.
- A source held high across a clear.
- A counter that jumps over several limits at once, or that falls back and then re-crosses a limit.

The scoreboard driver changes the strobe and the register write at the same falling edge to force the collision. It holds inputs high across several clocks to show that no second set happens. It steps the counters through exact boundary values (95/96, 127/128, 255/256) and through large single-cycle jumps in both directions. It queues the expected register and interrupt values for the edge where each change must appear.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

    // Error-confinement classification of one error counter
    typedef enum logic [1:0] {
        CS_ACTIVE  = 2'd0,
        CS_WARN    = 2'd1,
        CS_PASSIVE = 2'd2,
        CS_BUSOFF  = 2'd3
    } conf_state_t;

    // Edge-detected event sources
    localparam int EVT_RX   = 0;
    localparam int EVT_WAKE = 1;
    localparam int EVT_OVR  = 2;
    localparam int NUM_EVT  = 3;

    // Pulse-set confinement sources
    localparam int CF_RWARN = 0;
    localparam int CF_TWARN = 1;
    localparam int CF_RPASS = 2;
    localparam int CF_TPASS = 3;
    localparam int CF_BOFF  = 4;
    localparam int NUM_CF   = 5;

endpackage

// File: rtl/can_err_classifier.sv
module can_err_classifier
    import can_irq_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int WARN_LVL    = 96,
    parameter int PASSIVE_LVL = 127,
    parameter int BUSOFF_LVL  = 255,
    parameter bit HAS_BUSOFF  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             warn_rise_o,
    output logic             passive_rise_o,
    output logic             busoff_rise_o
);

    conf_state_t state_q, state_d;
    int          cnt_val;

    assign cnt_val = int'(cnt_i);

    // Classification of the current counter value
    always_comb begin
        if (HAS_BUSOFF && cnt_val > BUSOFF_LVL) begin
            state_d = CS_BUSOFF;
        end else if (cnt_val > PASSIVE_LVL) begin
            state_d = CS_PASSIVE;
        end else if (cnt_val >= WARN_LVL) begin
            state_d = CS_WARN;
        end else begin
            state_d = CS_ACTIVE;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // Upward transitions raise one pulse per crossed limit
    always_comb begin
        warn_rise_o    = 1'b0;
        passive_rise_o = 1'b0;
        busoff_rise_o  = 1'b0;
        unique case (state_q)
            CS_ACTIVE: begin
                warn_rise_o    = (state_d != CS_ACTIVE);
                passive_rise_o = (state_d == CS_PASSIVE) || (state_d == CS_BUSOFF);
                busoff_rise_o  = (state_d == CS_BUSOFF);
            end
            CS_WARN: begin
                passive_rise_o = (state_d == CS_PASSIVE) || (state_d == CS_BUSOFF);
                busoff_rise_o  = (state_d == CS_BUSOFF);
            end
            CS_PASSIVE: begin
                busoff_rise_o  = (state_d == CS_BUSOFF);
            end
            CS_BUSOFF: begin
                warn_rise_o    = 1'b0;
            end
            default: begin
                warn_rise_o    = 1'b0;
            end
        endcase
    end

    // A limit crossing is reported once, never on two cycles in a row
    assert_warn_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        warn_rise_o |=> !warn_rise_o);

    assert_passive_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        passive_rise_o |=> !passive_rise_o);

    // Bus-off state only for the transmit counter, only above its limit
    assert_busoff_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_BUSOFF) |-> (HAS_BUSOFF && ($past(cnt_val) > BUSOFF_LVL)));

endmodule

// File: rtl/can_flag_latch.sv
module can_flag_latch #(
    parameter int N    = 1,
    parameter bit EDGE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);

    logic [N-1:0] set_w;
    logic [N-1:0] flag_q;

    generate
        if (EDGE) begin : g_edge
            logic [N-1:0] cond_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cond_q <= '0;
                end else begin
                    cond_q <= cond_i;
                end
            end
            assign set_w = cond_i & ~cond_q;
        end else begin : g_pulse
            assign set_w = cond_i;
        end
    endgenerate

    // Set has priority over a write-one clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= set_w | (flag_q & ~clr_i);
        end
    end

    assign flag_o = flag_q;

    generate
        for (genvar k = 0; k < N; k++) begin : g_chk
            assert_set_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
                set_w[k] |=> flag_q[k]);
            assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_q[k] && clr_i[k] && !set_w[k]) |=> !flag_q[k]);
        end
    endgenerate

endmodule

// File: rtl/can_irq_aggregator.sv
module can_irq_aggregator
    import can_irq_pkg::*;
#(
    parameter int NUM_TXB     = 3,
    parameter int CNT_W       = 9,
    parameter int WARN_LVL    = 96,
    parameter int PASSIVE_LVL = 127,
    parameter int BUSOFF_LVL  = 255
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_TXB-1:0] buf_empty_i,
    input  logic               rx_done_i,
    input  logic               sleep_i,
    input  logic               bus_act_i,
    input  logic               overrun_i,
    input  logic [CNT_W-1:0]   rx_err_cnt_i,
    input  logic [CNT_W-1:0]   tx_err_cnt_i,
    input  logic               reg_wr_i,
    input  logic               reg_sel_i,
    input  logic [NUM_TXB+7:0] reg_wdata_i,
    output logic [NUM_TXB+7:0] reg_rdata_o,
    output logic               irq_tx_o,
    output logic               irq_rx_o,
    output logic               irq_wake_o,
    output logic               irq_err_o
);

    localparam int B_EVT  = NUM_TXB;           // first event flag (receive)
    localparam int B_OVR  = NUM_TXB + EVT_OVR; // first error-group flag
    localparam int B_CF   = NUM_TXB + NUM_EVT; // first confinement flag
    localparam int FLAG_W = NUM_TXB + NUM_EVT + NUM_CF;

    logic [NUM_TXB-1:0] tx_q;
    logic [FLAG_W-1:0]  en_q;
    logic [FLAG_W-1:0]  flags;
    logic [FLAG_W-1:0]  clr_w;
    logic [NUM_EVT-1:0] evt_cond, evt_flag;
    logic [NUM_CF-1:0]  cf_set, cf_flag;
    logic               irq_tx_q, irq_rx_q, irq_wake_q, irq_err_q;

    // Per-counter classifiers: index 0 receive, index 1 transmit
    logic [CNT_W-1:0] cnt_arr [2];
    logic [1:0]       warn_rise, passive_rise, busoff_rise;

    assign cnt_arr[0] = rx_err_cnt_i;
    assign cnt_arr[1] = tx_err_cnt_i;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_cls
            can_err_classifier #(
                .CNT_W      (CNT_W),
                .WARN_LVL   (WARN_LVL),
                .PASSIVE_LVL(PASSIVE_LVL),
                .BUSOFF_LVL (BUSOFF_LVL),
                .HAS_BUSOFF (g == 1)
            ) i_cls (
                .clk           (clk),
                .rst_n         (rst_n),
                .cnt_i         (cnt_arr[g]),
                .warn_rise_o   (warn_rise[g]),
                .passive_rise_o(passive_rise[g]),
                .busoff_rise_o (busoff_rise[g])
            );
        end
    endgenerate

    // Write-one-to-clear decode, flag register only
    assign clr_w = (reg_wr_i && !reg_sel_i) ? reg_wdata_i : '0;

    // Event sources
    assign evt_cond[EVT_RX]   = rx_done_i;
    assign evt_cond[EVT_WAKE] = sleep_i & bus_act_i;
    assign evt_cond[EVT_OVR]  = overrun_i;

    can_flag_latch #(.N(NUM_EVT), .EDGE(1'b1)) i_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .cond_i(evt_cond),
        .clr_i (clr_w[B_EVT +: NUM_EVT]),
        .flag_o(evt_flag)
    );

    // Confinement sources
    assign cf_set[CF_RWARN] = warn_rise[0];
    assign cf_set[CF_TWARN] = warn_rise[1];
    assign cf_set[CF_RPASS] = passive_rise[0];
    assign cf_set[CF_TPASS] = passive_rise[1];
    assign cf_set[CF_BOFF]  = |busoff_rise;

    can_flag_latch #(.N(NUM_CF), .EDGE(1'b0)) i_cf (
        .clk   (clk),
        .rst_n (rst_n),
        .cond_i(cf_set),
        .clr_i (clr_w[B_CF +: NUM_CF]),
        .flag_o(cf_flag)
    );

    // Transmit-empty status and enable register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '1;
            en_q <= '0;
        end else begin
            tx_q <= buf_empty_i;
            if (reg_wr_i && reg_sel_i) begin
                en_q <= reg_wdata_i;
            end
        end
    end

    assign flags       = {cf_flag, evt_flag, tx_q};
    assign reg_rdata_o = reg_sel_i ? en_q : flags;

    // Registered interrupt requests
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_tx_q   <= 1'b0;
            irq_rx_q   <= 1'b0;
            irq_wake_q <= 1'b0;
            irq_err_q  <= 1'b0;
        end else begin
            irq_tx_q   <= |(tx_q & en_q[NUM_TXB-1:0]);
            irq_rx_q   <= flags[B_EVT + EVT_RX] & en_q[B_EVT + EVT_RX];
            irq_wake_q <= flags[B_EVT + EVT_WAKE] & en_q[B_EVT + EVT_WAKE];
            irq_err_q  <= |(flags[FLAG_W-1:B_OVR] & en_q[FLAG_W-1:B_OVR]);
        end
    end

    assign irq_tx_o   = irq_tx_q;
    assign irq_rx_o   = irq_rx_q;
    assign irq_wake_o = irq_wake_q;
    assign irq_err_o  = irq_err_q;

    // Checks over ports and registered state
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    assert_tx_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (reg_sel_i || (reg_rdata_o[NUM_TXB-1:0] == $past(buf_empty_i))));

    assert_tx_irq_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_o |-> $past(|(tx_q & en_q[NUM_TXB-1:0])));

    assert_err_irq_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err_o |-> $past(|(flags[FLAG_W-1:B_OVR] & en_q[FLAG_W-1:B_OVR])));

    assert_rx_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[B_EVT + EVT_RX] |=> !irq_rx_o);

endmodule

// File: tb/test_can_irq_aggregator.sv
`timescale 1ns/1ps
module test_can_irq_aggregator;

    localparam time TCLK = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  buf_empty = 3'b111;
    logic        rx_done = 1'b0, sleep = 1'b0, bus_act = 1'b0, overrun = 1'b0;
    logic [8:0]  rx_cnt = '0, tx_cnt = '0;
    logic        reg_wr = 1'b0, reg_sel = 1'b0;
    logic [10:0] reg_wdata = '0;
    logic [10:0] reg_rdata;
    logic        irq_tx, irq_rx, irq_wake, irq_err;

    always #(TCLK/2) clk = ~clk;

    can_irq_aggregator i_can_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .buf_empty_i(buf_empty), .rx_done_i(rx_done),
        .sleep_i(sleep), .bus_act_i(bus_act), .overrun_i(overrun),
        .rx_err_cnt_i(rx_cnt), .tx_err_cnt_i(tx_cnt), .reg_wr_i(reg_wr),
        .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .irq_tx_o(irq_tx), .irq_rx_o(irq_rx), .irq_wake_o(irq_wake), .irq_err_o(irq_err)
    );

    // Observation vector: {irq_tx, irq_rx, irq_wake, irq_err, rdata[10:0]}
    localparam logic [14:0] I_TX = 15'h4000, I_RX = 15'h2000, I_WK = 15'h1000, I_ER = 15'h0800;
    localparam logic [14:0] RD = 15'h07FF;

    typedef struct {
        string       req;
        logic [14:0] mask;
        logic [14:0] exp;
    } item_t;

    item_t q[$];
    int    n_run = 0, n_fail = 0;
    bit    done = 1'b0;

    // Driver side: expectation for the state after the coming rising edge
    task automatic chk(string req, logic [14:0] mask, logic [14:0] exp);
        q.push_back('{req, mask, exp});
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Monitor: compare a quarter period after each rising edge
    always @(posedge clk) begin
        #(TCLK/4);
        while (q.size() > 0) begin
            item_t it;
            logic [14:0] obs;
            it  = q.pop_front();
            obs = {irq_tx, irq_rx, irq_wake, irq_err, reg_rdata};
            n_run++;
            if ((obs & it.mask) != (it.exp & it.mask)) begin
                n_fail++;
                $display("FAIL %s: actual=%h expected=%h (mask %h)",
                         it.req, obs & it.mask, it.exp & it.mask, it.mask);
            end
        end
    end

    initial begin
        #(TCLK * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(); reg_sel = 1'b0; chk("R1 flags", I_TX|I_RX|I_WK|I_ER|RD, 15'h0007);
        step(); reg_sel = 1'b1; chk("R1 enables", I_TX|I_RX|I_WK|I_ER|RD, 15'h0000);
        step(); rst_n = 1'b1; reg_sel = 1'b0;

        // R2: transmit-empty bits follow status, ignore writes
        step(); buf_empty = 3'b010; chk("R2 follow", 15'h0007, 15'h0002);
        step(); reg_wr = 1'b1; reg_wdata = 11'h007; chk("R2 write ignored", 15'h0007, 15'h0002);
        step(); reg_wr = 1'b0;

        // R3/R11: transmit interrupt, enable register
        step(); reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 11'h002; chk("R11 enable readback", RD, 15'h0002);
        step(); reg_wr = 1'b0; reg_sel = 1'b0; chk("R3 irq_tx on", I_TX, I_TX);
        step(); buf_empty = 3'b101; chk("R3 irq_tx latency", I_TX, I_TX);
        step(); chk("R3 irq_tx off", I_TX, 15'h0);
        step(); reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 11'h7F8; chk("R11 enable load", RD, 15'h07F8);

        // R4: receive flag on edge, held level sets once
        step(); reg_wr = 1'b0; reg_sel = 1'b0; rx_done = 1'b1; chk("R4 set", 15'h0008, 15'h0008);
        step(); chk("R4 irq_rx", I_RX, I_RX);
        step(); reg_wr = 1'b1; reg_wdata = 11'h008; chk("R6 clear", 15'h0008, 15'h0);
        step(); reg_wr = 1'b0; chk("R4 held no reset", I_RX | 15'h0008, 15'h0);
        step(); rx_done = 1'b0;
        step(); rx_done = 1'b1; chk("R4 new edge", 15'h0008, 15'h0008);

        // R6: set wins over same-cycle clear, zero write keeps
        step(); rx_done = 1'b0;
        step(); reg_wr = 1'b1; reg_wdata = 11'h008; rx_done = 1'b1; chk("R6 set wins", 15'h0008, 15'h0008);
        step(); reg_wr = 1'b0; rx_done = 1'b0;
        step(); reg_wr = 1'b1; reg_wdata = 11'h000; chk("R6 zero write keeps", 15'h0008, 15'h0008);
        step(); reg_wdata = 11'h008; chk("R6 clear after", 15'h0008, 15'h0);
        step(); reg_wr = 1'b0;

        // R5: wakeup only while asleep
        step(); bus_act = 1'b1; chk("R5 awake activity", 15'h0010, 15'h0);
        step(); bus_act = 1'b0;
        step(); sleep = 1'b1; chk("R5 sleep alone", 15'h0010, 15'h0);
        step(); bus_act = 1'b1; chk("R5 set", 15'h0010, 15'h0010);
        step(); bus_act = 1'b0; sleep = 1'b0; chk("R5 irq_wake", I_WK, I_WK);
        step(); reg_wr = 1'b1; reg_wdata = 11'h010; chk("R5 clear", 15'h0010, 15'h0);
        step(); reg_wr = 1'b0;

        // R10/R11: overrun and error interrupt masking
        step(); overrun = 1'b1; chk("R10 overrun set", 15'h0020, 15'h0020);
        step(); overrun = 1'b0; chk("R10 irq_err", I_ER, I_ER);
        step(); reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 11'h018;
        step(); reg_wr = 1'b0; reg_sel = 1'b0; chk("R11 masked", I_ER | 15'h0020, 15'h0020);
        step(); reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 11'h7F8;
        step(); reg_wr = 1'b0; reg_sel = 1'b0; chk("R11 late enable", I_ER, I_ER);
        step(); reg_wr = 1'b1; reg_wdata = 11'h020; chk("R10 clear", 15'h0020, 15'h0);
        step(); reg_wr = 1'b0; chk("R10 irq_err off", I_ER, 15'h0);

        // R7/R8/R9: receive counter limits
        step(); rx_cnt = 9'd95;  chk("R7 below", 15'h0040, 15'h0);
        step(); rx_cnt = 9'd96;  chk("R7 rx warn", 15'h0040, 15'h0040);
        step(); rx_cnt = 9'd127; chk("R8 at limit", 15'h0100, 15'h0);
        step(); rx_cnt = 9'd128; chk("R8 rx passive", 15'h0100, 15'h0100);
        step(); rx_cnt = 9'd300; chk("R9 rx no busoff", 15'h0400, 15'h0);
        step(); reg_wr = 1'b1; reg_wdata = 11'h140; chk("R6 level no reset", 15'h0140, 15'h0);
        step(); reg_wr = 1'b0; rx_cnt = 9'd10;
        step(); rx_cnt = 9'd200; chk("R12 rx jump", 15'h0140, 15'h0140);
        step(); reg_wr = 1'b1; reg_wdata = 11'h140; rx_cnt = 9'd0;
        step(); reg_wr = 1'b0;

        // R9/R12: transmit counter limits
        step(); tx_cnt = 9'd255; chk("R9 at 255", 15'h0680, 15'h0280);
        step(); tx_cnt = 9'd256; chk("R9 busoff", 15'h0400, 15'h0400);
        step(); tx_cnt = 9'd0;   chk("R10 irq_err busoff", I_ER, I_ER);
        step(); reg_wr = 1'b1; reg_wdata = 11'h7E0; chk("R6 clear all err", 15'h07E0, 15'h0);
        step(); reg_wr = 1'b0; tx_cnt = 9'd300; chk("R12 tx jump", 15'h0680, 15'h0680);
        step(); reg_wr = 1'b1; reg_wdata = 11'h680; tx_cnt = 9'd50; chk("R12 cleared", 15'h0680, 15'h0);
        step(); reg_wr = 1'b0; tx_cnt = 9'd100; chk("R12 recross", 15'h0680, 15'h0080);

        step(); step(); step();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule